// File: doc/BRIEF.md
# Shared-Memory Bus Isolation Controller

This block stands between a processor's external bus sequencer and the memory pins. It lets an outside bus master borrow the shared local memory without a request/grant exchange. Two active-low inputs drive the handshake: a wait request and a float request. While wait is low, the sequencer is told to halt and the pin values are frozen. If the float request is also low, every pin group stops being driven, so the outside master sees a released bus.

The expected order is fixed. Wait falls first and the float request falls second. The float request rises once the memory can be handed back. Wait rises last, when the data is ready. The interrupted access then resumes with exactly the values it held. The float decision depends only on these two inputs and on no bus configuration setting. Both inputs pass through a two-stage synchronizer, and every output enable comes straight from a flop.

The floated set has 66 pins:
- a 25-bit address
- a 32-bit data bus
- one chip select
- read/write direction
- a read strobe
- a row strobe
- a column/output-enable strobe
- four byte-lane strobes

Top module: `bus_iso_ctrl`

## Requirements
- R1: When wait_ni and hiz_ni are both low, isolated_o goes high on the third rising clock edge after both are low. From that edge on, addr_oe_o, ctrl_oe_o and data_oe_o are all low (pins floated).
- R2: A low hiz_ni while wait_ni is high is ignored. isolated_o stays low and addr_oe_o and ctrl_oe_o stay high.
- R3: halted_o rises on the second rising edge after wait_ni falls, and falls on the second rising edge after wait_ni rises. hiz_ni has no effect on it.
- R4: While halted_o is high, all pin value outputs hold the values captured before the halt, whatever the bus inputs do. When not halted, each pin output equals the matching bus input delayed by one clock.
- R5: When hiz_ni rises while wait_ni stays low, the enables return high on the third rising edge. The pins then carry the same held values they had before floating.
- R6: After reset, the outputs take these values: addr_o=0, data_o=0, and cs_no, rd_no, ras_no and cas_no high. In addition, rw_o=1 (read), we_no=4'hF, addr_oe_o=1, ctrl_oe_o=1, data_oe_o=0, halted_o=0 and isolated_o=0.
- R7: isolated_o falls on the third rising edge after wait_ni rises, even if hiz_ni stays low.
- R8: When not isolated, data_oe_o equals the registered data_drive_i, which is held like the pins during a halt. The three enables always switch together when floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| wait_ni | input | 1 | active-low wait request |
| hiz_ni | input | 1 | active-low float request |
| addr_i | input | 25 | address from sequencer |
| data_i | input | 32 | write data from sequencer |
| data_drive_i | input | 1 | sequencer wants the data bus driven |
| cs_ni | input | 1 | chip select from sequencer |
| rw_i | input | 1 | direction (1 read, 0 write) |
| rd_ni | input | 1 | read strobe from sequencer |
| ras_ni | input | 1 | row strobe from sequencer |
| cas_ni | input | 1 | column / output-enable strobe |
| we_ni | input | 4 | byte-lane strobes |
| addr_o | output | 25 | address pins |
| data_o | output | 32 | data pins |
| cs_no | output | 1 | chip select pin |
| rw_o | output | 1 | direction pin |
| rd_no | output | 1 | read strobe pin |
| ras_no | output | 1 | row strobe pin |
| cas_no | output | 1 | column strobe pin |
| we_no | output | 4 | byte-lane strobe pins |
| addr_oe_o | output | 1 | address pin enable |
| ctrl_oe_o | output | 1 | control / strobe pin enable |
| data_oe_o | output | 1 | data pin enable |
| halted_o | output | 1 | halt request to the sequencer |
| isolated_o | output | 1 | pins currently floated |

## Verification
A wrong synchronizer depth or float condition shows up as isolated_o or the enables moving one or more cycles away from the third edge after the input change. That difference is visible on the very cycle it happens.

A hold register that leaks during a halt changes a pin value in the first cycle after a bus input changes. The reference model compares every pin and enable on every clock, so the error appears within a cycle. A float request wrongly honoured without wait shows as a low enable three cycles after hiz_ni falls.

// File: rtl/bus_iso_pkg.sv
package bus_iso_pkg;
  localparam int ADDR_W  = 25;
  localparam int DATA_W  = 32;
  localparam int LANE_N  = 4;
  localparam int SYNC_N  = 2;
  localparam int PIN_CNT = ADDR_W + DATA_W + 5 + LANE_N;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              data_drv;
    logic              cs_n;
    logic              rw;
    logic              rd_n;
    logic              ras_n;
    logic              cas_n;
    logic [LANE_N-1:0] we_n;
  } bus_pins_t;

  localparam bus_pins_t PINS_IDLE = '{
    addr:     '0,
    data:     '0,
    data_drv: 1'b0,
    cs_n:     1'b1,
    rw:       1'b1,
    rd_n:     1'b1,
    ras_n:    1'b1,
    cas_n:    1'b1,
    we_n:     '1
  };
endpackage

// File: rtl/iso_sync.sv
module iso_sync #(
  parameter int   WIDTH  = 1,
  parameter int   STAGES = 2,
  parameter logic RST_V  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {WIDTH{RST_V}};
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/iso_pin_hold.sv
module iso_pin_hold
  import bus_iso_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  bus_pins_t pins_i,
  output bus_pins_t pins_next_o,
  output bus_pins_t pins_o
);
  bus_pins_t pins_q;

  // frozen copy keeps the interrupted cycle intact
  assign pins_next_o = hold_i ? pins_q : pins_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= PINS_IDLE;
    else         pins_q <= pins_next_o;
  end

  assign pins_o = pins_q;
endmodule

// File: rtl/iso_float_ctl.sv
module iso_float_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_s_ni,
  input  logic hiz_s_ni,
  input  logic drv_next_i,
  output logic halted_o,
  output logic float_o,
  output logic addr_oe_o,
  output logic ctrl_oe_o,
  output logic data_oe_o
);
  logic float_d;

  // both requests must be low; hiz alone is ignored
  assign float_d  = ~wait_s_ni & ~hiz_s_ni;
  assign halted_o = ~wait_s_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      float_o   <= 1'b0;
      addr_oe_o <= 1'b1;
      ctrl_oe_o <= 1'b1;
      data_oe_o <= 1'b0;
    end else begin
      float_o   <= float_d;
      addr_oe_o <= ~float_d;
      ctrl_oe_o <= ~float_d;
      data_oe_o <= drv_next_i & ~float_d;
    end
  end
endmodule

// File: rtl/bus_iso_ctrl.sv
module bus_iso_ctrl
  import bus_iso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_ni,
  input  logic              hiz_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              data_drive_i,
  input  logic              cs_ni,
  input  logic              rw_i,
  input  logic              rd_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic [LANE_N-1:0] we_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cs_no,
  output logic              rw_o,
  output logic              rd_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic [LANE_N-1:0] we_no,
  output logic              addr_oe_o,
  output logic              ctrl_oe_o,
  output logic              data_oe_o,
  output logic              halted_o,
  output logic              isolated_o
);
  logic [1:0] req_s;
  bus_pins_t  pins_in, pins_next, pins_q;

  iso_sync #(.WIDTH(2), .STAGES(SYNC_N), .RST_V(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wait_ni, hiz_ni}),
    .q_o    (req_s)
  );

  assign pins_in = '{
    addr:     addr_i,
    data:     data_i,
    data_drv: data_drive_i,
    cs_n:     cs_ni,
    rw:       rw_i,
    rd_n:     rd_ni,
    ras_n:    ras_ni,
    cas_n:    cas_ni,
    we_n:     we_ni
  };

  iso_pin_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (~req_s[1]),
    .pins_i      (pins_in),
    .pins_next_o (pins_next),
    .pins_o      (pins_q)
  );

  iso_float_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_s_ni  (req_s[1]),
    .hiz_s_ni   (req_s[0]),
    .drv_next_i (pins_next.data_drv),
    .halted_o   (halted_o),
    .float_o    (isolated_o),
    .addr_oe_o  (addr_oe_o),
    .ctrl_oe_o  (ctrl_oe_o),
    .data_oe_o  (data_oe_o)
  );

  assign addr_o = pins_q.addr;
  assign data_o = pins_q.data;
  assign cs_no  = pins_q.cs_n;
  assign rw_o   = pins_q.rw;
  assign rd_no  = pins_q.rd_n;
  assign ras_no = pins_q.ras_n;
  assign cas_no = pins_q.cas_n;
  assign we_no  = pins_q.we_n;
endmodule

// File: rtl/bus_iso_ctrl_chk.sv
module bus_iso_ctrl_chk
  import bus_iso_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o,
  input logic              cs_no,
  input logic              rw_o,
  input logic              rd_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic [LANE_N-1:0] we_no,
  input logic              addr_oe_o,
  input logic              ctrl_oe_o,
  input logic              data_oe_o,
  input logic              halted_o,
  input logic              isolated_o
);
  assert_float_needs_halt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolated_o |-> $past(halted_o));

  assert_float_all_groups_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isolated_o |-> (!addr_oe_o && !ctrl_oe_o && !data_oe_o));

  assert_driven_when_not_iso_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isolated_o |-> (addr_oe_o && ctrl_oe_o));

  assert_hold_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(addr_o) && $stable(data_o) && $stable(we_no) &&
                  $stable({cs_no, rw_o, rd_no, ras_no, cas_no})));

  assert_release_ends_iso_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |=> !isolated_o);
endmodule

bind bus_iso_ctrl bus_iso_ctrl_chk u_chk (.*);

// File: tb/bus_iso_ctrl_test.sv
module bus_iso_ctrl_test;
  import bus_iso_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_n = 1'b1, hiz_n = 1'b1;
  bus_pins_t drv = PINS_IDLE;

  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] data_o;
  logic cs_no, rw_o, rd_no, ras_no, cas_no;
  logic [LANE_N-1:0] we_no;
  logic addr_oe_o, ctrl_oe_o, data_oe_o, halted_o, isolated_o;

  int checks = 0, errors = 0, cycles = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_iso_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wait_ni(wait_n), .hiz_ni(hiz_n),
    .addr_i(drv.addr), .data_i(drv.data), .data_drive_i(drv.data_drv),
    .cs_ni(drv.cs_n), .rw_i(drv.rw), .rd_ni(drv.rd_n), .ras_ni(drv.ras_n),
    .cas_ni(drv.cas_n), .we_ni(drv.we_n),
    .addr_o(addr_o), .data_o(data_o), .cs_no(cs_no), .rw_o(rw_o),
    .rd_no(rd_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .addr_oe_o(addr_oe_o), .ctrl_oe_o(ctrl_oe_o), .data_oe_o(data_oe_o),
    .halted_o(halted_o), .isolated_o(isolated_o)
  );

  // reference model: input history queues, one-cycle output delay
  logic wq[$], hq[$];
  bus_pins_t m_pins;
  logic m_iso;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq = '{1'b1, 1'b1};
      hq = '{1'b1, 1'b1};
      m_pins = PINS_IDLE;
      m_iso = 1'b0;
    end else begin
      m_iso = !wq[0] && !hq[0];
      if (wq[0]) m_pins = drv;
      void'(wq.pop_front());
      void'(hq.pop_front());
      wq.push_back(wait_n);
      hq.push_back(hiz_n);
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && wq.size() == 2) begin
      chk("R3 halted", {63'd0, halted_o}, {63'd0, !wq[0]});
      chk("R1 isolated", {63'd0, isolated_o}, {63'd0, m_iso});
      chk("R8 enables", {61'd0, addr_oe_o, ctrl_oe_o, data_oe_o},
          {61'd0, !m_iso, !m_iso, m_pins.data_drv && !m_iso});
      chk("R4 addr", {39'd0, addr_o}, {39'd0, m_pins.addr});
      chk("R4 data", {32'd0, data_o}, {32'd0, m_pins.data});
      chk("R4 ctrl", {55'd0, cs_no, rw_o, rd_no, ras_no, cas_no, we_no},
          {55'd0, m_pins.cs_n, m_pins.rw, m_pins.rd_n, m_pins.ras_n,
           m_pins.cas_n, m_pins.we_n});
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  function automatic bus_pins_t rnd_pins();
    bus_pins_t p;
    seed = seed * 32'd1664525 + 32'd1013904223;
    p.addr = seed[ADDR_W-1:0];
    seed = seed * 32'd1664525 + 32'd1013904223;
    p.data = seed;
    seed = seed * 32'd1664525 + 32'd1013904223;
    {p.data_drv, p.cs_n, p.rw, p.rd_n, p.ras_n, p.cas_n, p.we_n} = seed[20:11];
    return p;
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drv = rnd_pins();
    end
  endtask

  logic [ADDR_W-1:0] held_addr;

  initial begin
    repeat (2) @(negedge clk);
    // R6 reset state
    chk("R6 addr", {39'd0, addr_o}, 64'd0);
    chk("R6 data", {32'd0, data_o}, 64'd0);
    chk("R6 ctrl", {55'd0, cs_no, rw_o, rd_no, ras_no, cas_no, we_no}, {55'd0, 9'h1FF});
    chk("R6 flags", {59'd0, addr_oe_o, ctrl_oe_o, data_oe_o, halted_o, isolated_o},
        {59'd0, 5'b11000});
    rst_n = 1'b1;
    step(20);

    // R2: float request alone is ignored
    @(negedge clk); hiz_n = 1'b0;
    step(8);
    chk("R2 iso", {63'd0, isolated_o}, 64'd0);
    chk("R2 oe", {62'd0, addr_oe_o, ctrl_oe_o}, {62'd0, 2'b11});
    @(negedge clk); hiz_n = 1'b1;
    step(4);

    // full protocol: wait, then hiz, release hiz, release wait
    @(negedge clk); wait_n = 1'b0; drv = rnd_pins();
    @(negedge clk); drv = rnd_pins();
    @(negedge clk); drv = rnd_pins();
    chk("R3 halt rise", {63'd0, halted_o}, 64'd1);
    held_addr = addr_o;
    step(3);
    @(negedge clk); hiz_n = 1'b0; drv = rnd_pins();
    @(negedge clk); drv = rnd_pins();
    @(negedge clk); drv = rnd_pins();
    chk("R1 before 3rd edge", {63'd0, isolated_o}, 64'd0);
    @(negedge clk); drv = rnd_pins();
    chk("R1 iso", {63'd0, isolated_o}, 64'd1);
    chk("R1 oe low", {61'd0, addr_oe_o, ctrl_oe_o, data_oe_o}, 64'd0);
    step(6);
    @(negedge clk); hiz_n = 1'b1; drv = rnd_pins();
    step(2);
    @(negedge clk); drv = rnd_pins();
    chk("R5 oe back", {62'd0, addr_oe_o, ctrl_oe_o}, {62'd0, 2'b11});
    chk("R5 held addr", {39'd0, addr_o}, {39'd0, held_addr});
    step(3);
    @(negedge clk); wait_n = 1'b1;
    step(6);
    chk("R3 halt fall", {63'd0, halted_o}, 64'd0);

    // R7: wait released while hiz still low
    @(negedge clk); wait_n = 1'b0;
    @(negedge clk); hiz_n = 1'b0;
    step(6);
    chk("R7 iso on", {63'd0, isolated_o}, 64'd1);
    @(negedge clk); wait_n = 1'b1;
    step(2);
    @(negedge clk);
    chk("R7 iso off", {63'd0, isolated_o}, 64'd0);
    @(negedge clk); hiz_n = 1'b1;

    // mixed random handshake traffic
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      drv = rnd_pins();
      seed = seed * 32'd1664525 + 32'd1013904223;
      if (seed[27:25] == 3'd0) wait_n = ~wait_n;
      if (seed[30:28] == 3'd0) hiz_n = ~hiz_n;
    end
    step(4);
    finish_run();
  end
endmodule